// File: doc/BRIEF.md
# Serial Port Control and Status Register Front End

This block is the byte-wide register face of an asynchronous serial port. Software reaches it through a simple read/write bus with eight byte registers. It holds the frame configuration and the transmit and receive data bytes. It tracks the transmit buffer and shifter hand-off, the receive-full flag and the three receive error flags. It drives four interrupt lines. The bit-level serialiser sits outside the block. The block tells the serialiser when to start a byte. In return it takes a frame-done strobe, a received-byte strobe and framing and break indications.

Two transmit flags are always valid. Buffer-empty says the data register can take a new byte. Transmit-end says the shifter is idle. A byte written while the shifter is idle starts at once. A byte written while a frame is in flight waits in the data register and starts when that frame ends. The error flags follow a read-then-write-zero protocol, so a flag that software has not yet seen cannot be lost. The two data-path interrupts (transmit and receive) are one-clock pulses. The error and transmit-end interrupts are levels.

Top module: `serial_port_csr`

## Requirements
- R1: After reset, offset 0 (frame mode) reads 0x00, offset 1 (rate) 0xFF, offset 2 (control) 0x00, offset 3 (transmit data) 0xFF, offset 4 (status) 0x84, offset 5 (receive data) 0x00, offsets 6 and 7 read 0x00, and all four interrupt outputs are low.
- R2: Only address bits 2:0 select a register. Address 8+k and address 0xF8+k reach the same register as offset k.
- R3: Writes to offsets 0 and 1 are ignored while control bit 5 (transmit enable) or control bit 4 (receive enable) is set. Otherwise they are stored.
- R4: A control write with bit 5 set forces status bit 7 (buffer empty) and status bit 2 (transmit end) to 1. If bit 7 of the written value (transmit interrupt enable) is set, irq_txi is high for exactly the one cycle after the write.
- R5: A write to offset 3 while status bit 2 is 1 starts the byte. eng_tx_load is high for one cycle after the write with eng_tx_data equal to the byte, status bit 2 becomes 0 and bit 7 stays 1, irq_tei drops, and irq_txi pulses if control bit 7 is set.
- R6: A write to offset 3 while status bit 2 is 0 clears status bit 7 and raises no load. The next eng_frame_done then starts the buffered byte as in R5.
- R7: An eng_frame_done while status bit 7 is 1 sets status bit 2. If control bit 2 (transmit-end interrupt enable) is set, it also raises irq_tei, which stays high until the next byte starts or until control bit 2 is cleared.
- R8: With control bit 4 set and status bit 6 (receive full) clear, a received byte is stored at offset 5, sets status bit 6 and pulses irq_rxi for one cycle if control bit 6 (receive interrupt enable) is set. With control bit 4 clear, received bytes are ignored.
- R9: A byte received while status bit 6 is set is dropped. It sets status bit 5 (overrun) and raises irq_err if control bit 6 is set.
- R10: A read of offset 5 returns the stored byte and clears status bit 6.
- R11: eng_break or eng_rx_ferr sets status bit 4 (framing error) and raises irq_err if control bit 6 is set.
- R12: A status write stores bit 0. Each error bit (5 overrun, 4 framing, 3 parity) clears only when written 0 after a status read that returned it as 1. Writing 1, or writing 0 before such a read, leaves it set. irq_err drops when a status write leaves all three error bits at 0.
- R13: A control write with bit 2 clear drops irq_tei. A control write with bit 6 clear drops irq_err.
- R14: Writes to offset 5 have no effect on the receive data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr | input | ADDR_W | Register address, low 3 bits decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| cfg_mode | output | 8 | Frame mode register to the serialiser |
| cfg_rate | output | 8 | Bit-rate register to the serialiser |
| cfg_ctrl | output | 8 | Control register to the serialiser |
| eng_tx_load | output | 1 | One-cycle start strobe for the serialiser |
| eng_tx_data | output | 8 | Byte to send, valid with eng_tx_load |
| eng_frame_done | input | 1 | Serialiser finished a transmit frame |
| eng_rx_valid | input | 1 | Serialiser delivered a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ferr | input | 1 | Framing error on the received frame |
| eng_break | input | 1 | Line break detected |
| irq_err | output | 1 | Receive error interrupt, level |
| irq_rxi | output | 1 | Receive data interrupt, one-cycle pulse |
| irq_txi | output | 1 | Transmit buffer interrupt, one-cycle pulse |
| irq_tei | output | 1 | Transmit end interrupt, level |

## Verification
The bench builds the block with ADDR_W at its default of 8. The five address bits above the decoded three are then free to drive, so aliasing at 0x08 and 0xF8 can be shown to reach the same register. A directed pass walks the transmit hand-off, overrun, the read-then-clear error protocol and the interrupt enables. A seeded random pass then mixes data writes, frame ends, received bytes, breaks and status accesses against a flag model. This reaches overrun on back-to-back receptions and frame ends with an empty buffer.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int BYTE_W  = 8;
    localparam int REG_CNT = 8;
    localparam int OFS_W   = $clog2(REG_CNT);
    localparam int ERR_W   = 3;

    // error flag indices inside the 3-bit error group
    localparam int ERR_PAR = 0;
    localparam int ERR_FRM = 1;
    localparam int ERR_OVR = 2;

    typedef enum logic [OFS_W-1:0] {
        OFS_MODE = 3'd0,
        OFS_RATE = 3'd1,
        OFS_CTRL = 3'd2,
        OFS_TXD  = 3'd3,
        OFS_STAT = 3'd4,
        OFS_RXD  = 3'd5,
        OFS_CARD = 3'd6,
        OFS_EXT  = 3'd7
    } reg_ofs_e;

    typedef struct packed {
        logic       tx_ie;
        logic       rx_ie;
        logic       tx_en;
        logic       rx_en;
        logic       mp_ie;
        logic       te_ie;
        logic [1:0] clk_en;
    } ctrl_t;

    typedef struct packed {
        logic             tdre;
        logic             rdrf;
        logic [ERR_W-1:0] err;
        logic             tend;
        logic             mpb;
        logic             mpbt;
    } stat_t;

    localparam logic [BYTE_W-1:0] RST_MODE = 8'h00;
    localparam logic [BYTE_W-1:0] RST_RATE = 8'hFF;
    localparam logic [BYTE_W-1:0] RST_TXD  = 8'hFF;
    localparam logic [BYTE_W-1:0] RST_RXD  = 8'h00;
    localparam logic [BYTE_W-1:0] RST_AUX  = 8'h00;

    function automatic logic [BYTE_W-1:0] pack_stat(input stat_t s);
        return s;
    endfunction

    function automatic logic [ERR_W-1:0] clear_mask(input logic [ERR_W-1:0] seen,
                                                    input logic [ERR_W-1:0] wbits);
        return seen & ~wbits;
    endfunction

endpackage

// File: rtl/sercom_cfg.sv
module sercom_cfg
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic              wr_rate,
    input  logic              wr_ctrl,
    input  logic              wr_card,
    input  logic              wr_ext,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] rate_q,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] card_q,
    output logic [BYTE_W-1:0] ext_q
);

    logic frame_locked;
    assign frame_locked = ctrl_q.tx_en | ctrl_q.rx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RST_MODE;
            rate_q <= RST_RATE;
            ctrl_q <= '0;
            card_q <= RST_AUX;
            ext_q  <= RST_AUX;
        end else begin
            if (wr_mode && !frame_locked) mode_q <= wdata;
            if (wr_rate && !frame_locked) rate_q <= wdata;
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata);
            if (wr_card) card_q <= wdata;
            if (wr_ext)  ext_q  <= wdata;
        end
    end

endmodule

// File: rtl/sercom_txctl.sv
module sercom_txctl
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              w_tx_en,
    input  logic              w_te_ie,
    input  logic              w_tx_ie,
    input  logic              te_ie,
    input  logic              tx_ie,
    input  logic              txd_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              frame_done,
    output logic              tdre_q,
    output logic              tend_q,
    output logic [BYTE_W-1:0] txd_q,
    output logic              load_q,
    output logic [BYTE_W-1:0] load_data_q,
    output logic              irq_txi_q,
    output logic              irq_tei_q
);

    logic              n_tdre, n_tend, n_tei, n_txi, start;
    logic [BYTE_W-1:0] n_txd, start_byte;

    always_comb begin
        n_tdre     = tdre_q;
        n_tend     = tend_q;
        n_tei      = irq_tei_q;
        n_txd      = txd_q;
        start      = 1'b0;
        start_byte = txd_q;

        // frame end: chain the buffered byte or go idle
        if (frame_done) begin
            if (!tdre_q) begin
                start = 1'b1;
            end else begin
                n_tend = 1'b1;
                if (te_ie) n_tei = 1'b1;
            end
        end
        if (start) begin
            n_tend = 1'b0;
            n_tdre = 1'b1;
            n_tei  = 1'b0;
        end

        // data write: start now if the shifter is idle, else hold
        if (txd_wr) begin
            n_txd = wdata;
            if (n_tend) begin
                start      = 1'b1;
                start_byte = wdata;
                n_tend     = 1'b0;
                n_tdre     = 1'b1;
                n_tei      = 1'b0;
            end else begin
                n_tdre = 1'b0;
            end
        end

        if (ctrl_wr) begin
            if (w_tx_en) begin
                n_tdre = 1'b1;
                n_tend = 1'b1;
            end
            if (!w_te_ie) n_tei = 1'b0;
        end

        n_txi = (start && tx_ie) || (ctrl_wr && w_tx_en && w_tx_ie);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tdre_q      <= 1'b1;
            tend_q      <= 1'b1;
            txd_q       <= RST_TXD;
            load_q      <= 1'b0;
            load_data_q <= RST_TXD;
            irq_txi_q   <= 1'b0;
            irq_tei_q   <= 1'b0;
        end else begin
            tdre_q    <= n_tdre;
            tend_q    <= n_tend;
            txd_q     <= n_txd;
            load_q    <= start;
            irq_txi_q <= n_txi;
            irq_tei_q <= n_tei;
            if (start) load_data_q <= start_byte;
        end
    end

endmodule

// File: rtl/sercom_rxctl.sv
module sercom_rxctl
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              w_rx_ie,
    input  logic              rx_en,
    input  logic              rx_ie,
    input  logic              rxd_rd,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              w_mpbt,
    input  logic [ERR_W-1:0]  w_err,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_ferr,
    input  logic              rx_break,
    output logic              rdrf_q,
    output logic [ERR_W-1:0]  err_q,
    output logic              mpbt_q,
    output logic [BYTE_W-1:0] rxd_q,
    output logic              irq_rxi_q,
    output logic              irq_err_q
);

    logic [ERR_W-1:0]  seen_q, n_seen, n_err, clr;
    logic [BYTE_W-1:0] n_rxd;
    logic              n_rdrf, n_mpbt, n_irq, n_rxi;

    always_comb begin
        n_rdrf = rdrf_q;
        n_err  = err_q;
        n_seen = seen_q;
        n_mpbt = mpbt_q;
        n_irq  = irq_err_q;
        n_rxd  = rxd_q;
        n_rxi  = 1'b0;
        clr    = '0;

        // bus side first, so a read and a new byte in one cycle both land
        if (rxd_rd) n_rdrf = 1'b0;
        if (stat_rd) n_seen = err_q;
        if (stat_wr) begin
            n_mpbt = w_mpbt;
            clr    = clear_mask(seen_q, w_err);
            n_err  = err_q & ~clr;
            n_seen = seen_q & ~clr;
            if (n_err == '0) n_irq = 1'b0;
        end
        if (ctrl_wr && !w_rx_ie) n_irq = 1'b0;

        // serialiser side
        if (rx_valid && rx_en) begin
            if (n_rdrf) begin
                n_err[ERR_OVR] = 1'b1;
                if (rx_ie) n_irq = 1'b1;
            end else begin
                n_rxd  = rx_data;
                n_rdrf = 1'b1;
                n_rxi  = rx_ie;
            end
        end
        if (rx_ferr || rx_break) begin
            n_err[ERR_FRM] = 1'b1;
            if (rx_ie) n_irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdrf_q    <= 1'b0;
            err_q     <= '0;
            seen_q    <= '0;
            mpbt_q    <= 1'b0;
            rxd_q     <= RST_RXD;
            irq_rxi_q <= 1'b0;
            irq_err_q <= 1'b0;
        end else begin
            rdrf_q    <= n_rdrf;
            err_q     <= n_err;
            seen_q    <= n_seen;
            mpbt_q    <= n_mpbt;
            rxd_q     <= n_rxd;
            irq_rxi_q <= n_rxi;
            irq_err_q <= n_irq;
        end
    end

endmodule

// File: rtl/serial_port_csr.sv
module serial_port_csr
    import sercom_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        cfg_mode,
    output logic [7:0]        cfg_rate,
    output logic [7:0]        cfg_ctrl,
    output logic              eng_tx_load,
    output logic [7:0]        eng_tx_data,
    input  logic              eng_frame_done,
    input  logic              eng_rx_valid,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_rx_ferr,
    input  logic              eng_break,
    output logic              irq_err,
    output logic              irq_rxi,
    output logic              irq_txi,
    output logic              irq_tei
);

    logic [OFS_W-1:0]   ofs;
    logic [REG_CNT-1:0] wr_hit, rd_hit;

    assign ofs = bus_addr[OFS_W-1:0];

    generate
        if (ADDR_W > OFS_W) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
        end
        for (genvar g = 0; g < REG_CNT; g++) begin : g_dec
            assign wr_hit[g] = bus_wr && (ofs == OFS_W'(g));
            assign rd_hit[g] = bus_rd && (ofs == OFS_W'(g));
        end
    endgenerate

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] mode_q, rate_q, card_q, ext_q, txd_q, rxd_q;
    logic              tdre, tend, rdrf, mpbt;
    logic [ERR_W-1:0]  err;
    stat_t             stat;
    logic [BYTE_W-1:0] stat_byte;

    sercom_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_mode (wr_hit[OFS_MODE]),
        .wr_rate (wr_hit[OFS_RATE]),
        .wr_ctrl (wr_hit[OFS_CTRL]),
        .wr_card (wr_hit[OFS_CARD]),
        .wr_ext  (wr_hit[OFS_EXT]),
        .wdata   (bus_wdata),
        .mode_q  (mode_q),
        .rate_q  (rate_q),
        .ctrl_q  (ctrl_q),
        .card_q  (card_q),
        .ext_q   (ext_q)
    );

    sercom_txctl u_tx (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (wr_hit[OFS_CTRL]),
        .w_tx_en     (bus_wdata[5]),
        .w_te_ie     (bus_wdata[2]),
        .w_tx_ie     (bus_wdata[7]),
        .te_ie       (ctrl_q.te_ie),
        .tx_ie       (ctrl_q.tx_ie),
        .txd_wr      (wr_hit[OFS_TXD]),
        .wdata       (bus_wdata),
        .frame_done  (eng_frame_done),
        .tdre_q      (tdre),
        .tend_q      (tend),
        .txd_q       (txd_q),
        .load_q      (eng_tx_load),
        .load_data_q (eng_tx_data),
        .irq_txi_q   (irq_txi),
        .irq_tei_q   (irq_tei)
    );

    sercom_rxctl u_rx (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (wr_hit[OFS_CTRL]),
        .w_rx_ie   (bus_wdata[6]),
        .rx_en     (ctrl_q.rx_en),
        .rx_ie     (ctrl_q.rx_ie),
        .rxd_rd    (rd_hit[OFS_RXD]),
        .stat_rd   (rd_hit[OFS_STAT]),
        .stat_wr   (wr_hit[OFS_STAT]),
        .w_mpbt    (bus_wdata[0]),
        .w_err     (bus_wdata[5:3]),
        .rx_valid  (eng_rx_valid),
        .rx_data   (eng_rx_data),
        .rx_ferr   (eng_rx_ferr),
        .rx_break  (eng_break),
        .rdrf_q    (rdrf),
        .err_q     (err),
        .mpbt_q    (mpbt),
        .rxd_q     (rxd_q),
        .irq_rxi_q (irq_rxi),
        .irq_err_q (irq_err)
    );

    always_comb begin
        stat      = '0;
        stat.tdre = tdre;
        stat.rdrf = rdrf;
        stat.err  = err;
        stat.tend = tend;
        stat.mpbt = mpbt;
        stat_byte = pack_stat(stat);
    end

    always_comb begin
        unique case (reg_ofs_e'(ofs))
            OFS_MODE: bus_rdata = mode_q;
            OFS_RATE: bus_rdata = rate_q;
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_TXD:  bus_rdata = txd_q;
            OFS_STAT: bus_rdata = stat_byte;
            OFS_RXD:  bus_rdata = rxd_q;
            OFS_CARD: bus_rdata = card_q;
            OFS_EXT:  bus_rdata = ext_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign cfg_mode = mode_q;
    assign cfg_rate = rate_q;
    assign cfg_ctrl = ctrl_q;

endmodule

// File: rtl/sercom_csr_chk.sv
module sercom_csr_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] ofs,
    input logic [7:0] bus_wdata,
    input logic [7:0] stat_byte,
    input logic [7:0] cfg_mode,
    input logic [7:0] cfg_rate,
    input logic [7:0] cfg_ctrl,
    input logic       eng_tx_load,
    input logic [7:0] eng_tx_data,
    input logic       eng_rx_valid,
    input logic       irq_err,
    input logic       irq_rxi,
    input logic       irq_txi,
    input logic       irq_tei
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_byte == 8'h84 && cfg_mode == 8'h00 && cfg_rate == 8'hFF
                        && !irq_err && !irq_rxi && !irq_txi && !irq_tei));

    // R3
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ofs == 3'd0 && (cfg_ctrl[5] || cfg_ctrl[4])) |=> $stable(cfg_mode));

    // R3
    rate_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ofs == 3'd1 && (cfg_ctrl[5] || cfg_ctrl[4])) |=> $stable(cfg_rate));

    // R5
    direct_start_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ofs == 3'd3 && stat_byte[2]) |=> (eng_tx_load && eng_tx_data == $past(bus_wdata)));

    // R7
    tei_needs_tend_chk: assert property (@(posedge clk) disable iff (rst)
        irq_tei |-> stat_byte[2]);

    // R8
    rxi_with_full_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rxi |-> stat_byte[6]);

    // R9
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_valid && cfg_ctrl[4] && stat_byte[6] && !(bus_rd && ofs == 3'd5)) |=> stat_byte[5]);

    // R10
    read_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ofs == 3'd5 && !eng_rx_valid) |=> !stat_byte[6]);

    // R13
    tei_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ofs == 3'd2 && !bus_wdata[2]) |=> !irq_tei);

endmodule

bind serial_port_csr sercom_csr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .ofs          (ofs),
    .bus_wdata    (bus_wdata),
    .stat_byte    (stat_byte),
    .cfg_mode     (cfg_mode),
    .cfg_rate     (cfg_rate),
    .cfg_ctrl     (cfg_ctrl),
    .eng_tx_load  (eng_tx_load),
    .eng_tx_data  (eng_tx_data),
    .eng_rx_valid (eng_rx_valid),
    .irq_err      (irq_err),
    .irq_rxi      (irq_rxi),
    .irq_txi      (irq_txi),
    .irq_tei      (irq_tei)
);

// File: tb/tb_serial_port_csr.sv
module tb_serial_port_csr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata, cfg_mode, cfg_rate, cfg_ctrl, eng_tx_data;
    logic       eng_tx_load;
    logic       eng_frame_done = 1'b0, eng_rx_valid = 1'b0, eng_rx_ferr = 1'b0, eng_break = 1'b0;
    logic [7:0] eng_rx_data = '0;
    logic       irq_err, irq_rxi, irq_txi, irq_tei;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_port_csr #(.ADDR_W(8)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic eng(input logic fd, input logic rv, input logic [7:0] rb,
                       input logic fe, input logic bk);
        eng_frame_done = fd; eng_rx_valid = rv; eng_rx_data = rb;
        eng_rx_ferr = fe; eng_break = bk;
        @(posedge clk); #1;
        eng_frame_done = 1'b0; eng_rx_valid = 1'b0; eng_rx_ferr = 1'b0; eng_break = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // bench flag model for the random pass
    logic       m_tdre, m_tend, m_rdrf, m_mpbt, m_tei, m_ierr;
    logic [2:0] m_err, m_seen;
    logic [7:0] m_rdr, m_buf;

    function automatic logic [7:0] exp_stat();
        return {m_tdre, m_rdrf, m_err, m_tend, 1'b0, m_mpbt};
    endfunction

    function automatic logic [7:0] exp_reset_val(input int k);
        case (k)
            1, 3:    return 8'hFF;
            4:       return 8'h84;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1207));
        do_reset();

        // R1 reset state
        for (int k = 0; k < 8; k++) begin
            rd(8'(k), d);
            chk("R1", d, exp_reset_val(k));
        end
        chk("R1", {irq_err, irq_rxi, irq_txi, irq_tei}, 4'b0000);

        // R2 aliasing
        wr(8'h08, 8'h5A);
        rd(8'h00, d); chk("R2", d, 8'h5A);
        rd(8'hF8, d); chk("R2", d, 8'h5A);
        wr(8'hFE, 8'h3C);
        rd(8'h06, d); chk("R2", d, 8'h3C);

        // R3 mode/rate lock
        wr(8'h01, 8'h33);
        rd(8'h01, d); chk("R3", d, 8'h33);
        wr(8'h02, 8'h10);
        wr(8'h00, 8'h11);
        rd(8'h00, d); chk("R3", d, 8'h5A);
        wr(8'h01, 8'h44);
        rd(8'h01, d); chk("R3", d, 8'h33);
        wr(8'h02, 8'h20);
        wr(8'h00, 8'h22);
        rd(8'h00, d); chk("R3", d, 8'h5A);
        wr(8'h02, 8'h00);
        wr(8'h00, 8'h00);
        rd(8'h00, d); chk("R3", d, 8'h00);

        // R14 receive data not writable
        wr(8'h05, 8'h77);
        rd(8'h05, d); chk("R14", d, 8'h00);

        // R4 transmit enable
        wr(8'h02, 8'hA4);
        chk("R4", irq_txi, 1'b1);
        idle();
        chk("R4", irq_txi, 1'b0);
        rd(8'h04, d); chk("R4", d, 8'h84);

        // R5 direct start
        wr(8'h03, 8'hC3);
        chk("R5", {eng_tx_load, irq_txi}, 2'b11);
        chk("R5", eng_tx_data, 8'hC3);
        rd(8'h04, d); chk("R5", d, 8'h80);

        // R6 buffered byte
        wr(8'h03, 8'h5E);
        chk("R6", {eng_tx_load, irq_txi}, 2'b00);
        rd(8'h04, d); chk("R6", d, 8'h00);
        eng(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R6", {eng_tx_load, irq_txi}, 2'b11);
        chk("R6", eng_tx_data, 8'h5E);
        rd(8'h04, d); chk("R6", d, 8'h80);

        // R7 transmit end, R13 enable clear
        eng(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R7", irq_tei, 1'b1);
        idle(); idle();
        chk("R7", irq_tei, 1'b1);
        rd(8'h04, d); chk("R7", d, 8'h84);
        wr(8'h02, 8'hA0);
        chk("R13", irq_tei, 1'b0);
        wr(8'h02, 8'hA4);
        eng(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R7", irq_tei, 1'b1);
        wr(8'h03, 8'h66);
        chk("R7", {irq_tei, eng_tx_load}, 2'b01);

        // R8 receive gating and store
        wr(8'h02, 8'h40);
        eng(1'b0, 1'b1, 8'h9A, 1'b0, 1'b0);
        chk("R8", irq_rxi, 1'b0);
        rd(8'h04, d); chk("R8", d[6], 1'b0);
        wr(8'h02, 8'h50);
        eng(1'b0, 1'b1, 8'h9A, 1'b0, 1'b0);
        chk("R8", irq_rxi, 1'b1);
        idle();
        chk("R8", irq_rxi, 1'b0);
        rd(8'h04, d); chk("R8", d[6], 1'b1);

        // R9 overrun
        eng(1'b0, 1'b1, 8'h11, 1'b0, 1'b0);
        chk("R9", {irq_err, irq_rxi}, 2'b10);

        // R12 read-then-write-zero
        wr(8'h04, 8'h00);
        chk("R12", irq_err, 1'b1);
        rd(8'h04, d); chk("R12", d[5], 1'b1);
        wr(8'h04, 8'h20);
        rd(8'h04, d); chk("R12", d[5], 1'b1);
        wr(8'h04, 8'h01);
        chk("R12", irq_err, 1'b0);
        rd(8'h04, d); chk("R12", {d[5], d[0]}, 2'b01);

        // R10 read clears receive full, old byte kept on overrun (R9)
        rd(8'h05, d); chk("R9", d, 8'h9A);
        rd(8'h04, d); chk("R10", d[6], 1'b0);

        // R11 break and framing
        eng(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R11", irq_err, 1'b1);
        rd(8'h04, d); chk("R11", d[4], 1'b1);
        wr(8'h02, 8'h10);
        chk("R13", irq_err, 1'b0);
        wr(8'h04, 8'h00);
        rd(8'h04, d); chk("R12", d[4], 1'b0);
        eng(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R11", irq_err, 1'b0);
        rd(8'h04, d); chk("R11", d[4], 1'b1);

        // random pass
        do_reset();
        wr(8'h02, 8'hF4);
        m_tdre = 1; m_tend = 1; m_rdrf = 0; m_mpbt = 0; m_tei = 0; m_ierr = 0;
        m_err = '0; m_seen = '0; m_rdr = 8'h00; m_buf = 8'hFF;
        idle();
        for (int i = 0; i < 1500; i++) begin
            int unsigned op;
            logic [7:0] v, e_data;
            logic e_load, e_txi, e_rxi;
            logic [2:0] clr;
            op = $urandom_range(0, 6);
            v = 8'($urandom);
            e_load = 0; e_txi = 0; e_rxi = 0; e_data = 8'h00;
            case (op)
                0: begin // R5 R6
                    wr(8'h03, v);
                    if (m_tend) begin
                        e_load = 1; e_data = v; e_txi = 1;
                        m_tend = 0; m_tdre = 1; m_tei = 0;
                    end else begin
                        m_tdre = 0; m_buf = v;
                    end
                end
                1: begin // R6 R7
                    eng(1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
                    if (!m_tdre) begin
                        e_load = 1; e_data = m_buf; e_txi = 1;
                        m_tdre = 1; m_tend = 0; m_tei = 0;
                    end else begin
                        m_tend = 1; m_tei = 1;
                    end
                end
                2: begin // R8 R9
                    eng(1'b0, 1'b1, v, 1'b0, 1'b0);
                    if (m_rdrf) begin
                        m_err[2] = 1; m_ierr = 1;
                    end else begin
                        m_rdr = v; m_rdrf = 1; e_rxi = 1;
                    end
                end
                3: begin // R10
                    rd(8'h05, v);
                    chk("R10", v, m_rdr);
                    m_rdrf = 0;
                end
                4: begin // R12
                    rd(8'h04, v);
                    chk("R12", v, exp_stat());
                    m_seen = m_err;
                end
                5: begin // R12
                    wr(8'h04, v);
                    m_mpbt = v[0];
                    clr = m_seen & ~v[5:3];
                    m_err = m_err & ~clr;
                    m_seen = m_seen & ~clr;
                    if (m_err == 3'b000) m_ierr = 0;
                end
                default: begin // R11
                    eng(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
                    m_err[1] = 1; m_ierr = 1;
                end
            endcase
            chk("R5", eng_tx_load, e_load);
            if (e_load) chk("R6", eng_tx_data, e_data);
            chk("R5", irq_txi, e_txi);
            chk("R8", irq_rxi, e_rxi);
            chk("R9", irq_err, m_ierr);
            chk("R7", irq_tei, m_tei);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule